// File: doc/BRIEF.md
# Accumulator ALU with Destination Select

This block is the execute stage of an 8-bit accumulator machine. Each cycle in which `op_valid` is high, it takes a decoded operation code and combines the accumulator with either a register operand (read from an external register file) or an 8-bit literal. The result goes to one of two places: the accumulator, which this block holds, or back to the register file through `reg_wdata` and `reg_we`. Register-operand operations pick the target with `dest_reg`. The block also holds the zero, carry and digit-carry flags.

The write-back data, write enable and skip request are combinational. They are valid in the same cycle as the operation, so the register file captures them at the closing clock edge. The accumulator and the flags update on that same edge. Skip variants of increment and decrement raise `skip` when their result is zero, and the fetch logic around the block uses it to drop the next instruction. Codes that are not listed act as no-operation.

Top module: `acu_exec`

## Requirements
- R1: While `rst_n` is low, and right after it rises, the accumulator and the Z, C and DC flags are 0. `reg_we` and `skip` are low while `op_valid` is low.
- R2: ADD (code 1) gives accumulator + register. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the 8-bit result is 0.
- R3: SUB (code 2) gives register − accumulator. C is 1 when no borrow occurs (register ≥ accumulator). DC is 1 when the low nibble has no borrow (register[3:0] ≥ accumulator[3:0]). Z is set when the result is 0.
- R4: AND (3), OR (4) and XOR (5) combine the accumulator with the register. NOT (6) inverts the register. CLR (7) gives 0. MOV (8) passes the register through. All of these update Z and leave C and DC unchanged.
- R5: For codes 1–15, `dest_reg`=1 sends the result to `reg_wdata` with `reg_we` high and leaves the accumulator unchanged. `dest_reg`=0 loads the accumulator and keeps `reg_we` low.
- R6: ANDI (19), ORI (20) and XORI (21) combine the accumulator with `imm`, write the accumulator and update Z. MOVI (22) loads `imm` into the accumulator and changes no flag. `dest_reg` has no effect on these four.
- R7: INC (9) and DEC (10) add or subtract 1 from the register, wrapping modulo 256. They update Z only.
- R8: INCSZ (11) and DECSZ (12) compute the same results as INC and DEC. `skip` is high in the same cycle exactly when the result is 0. No flag changes.
- R9: ROL (13) gives {reg[6:0], C} with the new C = reg[7]. ROR (14) gives {C, reg[7:1]} with the new C = reg[0]. Z and DC are unchanged.
- R10: SWAP (15) exchanges the register's two nibbles and changes no flag.
- R11: BSET (16) and BCLR (17) set or clear bit `bit_sel` (0–7) of the register. The result is always written to the register regardless of `dest_reg`, and no flag changes.
- R12: MOVA (18) writes the accumulator to the register with `reg_we` high and changes no flag.
- R13: With `op_valid` low, or with an unlisted code (0 or 23–31), `reg_we` and `skip` stay low and the accumulator and flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Decoded operation code |
| dest_reg | input | 1 | 1: result to register, 0: to accumulator |
| reg_rdata | input | 8 | Register operand |
| imm | input | 8 | Literal operand |
| bit_sel | input | 3 | Bit index for bit set and clear |
| reg_wdata | output | 8 | Write-back data to the register file |
| reg_we | output | 1 | Write-back enable |
| skip | output | 1 | Request to skip the next instruction |
| acc | output | 8 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_dc | output | 1 | Digit-carry flag |

## Verification
A skip request and a register write-back can fall in the same cycle. This happens when INCSZ or DECSZ is issued with `dest_reg`=1 on an operand of 255 or 1. The bench sweeps all 256 operands through both skip codes with both destination settings. In every cycle it checks `skip`, `reg_we` and `reg_wdata` together, and after the edge it checks that the accumulator and Z held. A second overlap is a rotate that changes C while Z must keep its value. Rotates run over all operands with whatever carry the previous step left behind.

// File: rtl/acu_pkg.sv
package acu_pkg;
  typedef enum logic [4:0] {
    OP_NOP   = 5'd0,  OP_ADD  = 5'd1,  OP_SUB  = 5'd2,  OP_AND  = 5'd3,
    OP_OR    = 5'd4,  OP_XOR  = 5'd5,  OP_NOT  = 5'd6,  OP_CLR  = 5'd7,
    OP_MOV   = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_INCSZ = 5'd11,
    OP_DECSZ = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_SWAP = 5'd15,
    OP_BSET  = 5'd16, OP_BCLR = 5'd17, OP_MOVA = 5'd18, OP_ANDI = 5'd19,
    OP_ORI   = 5'd20, OP_XORI = 5'd21, OP_MOVI = 5'd22
  } acu_op_e;

  // where a result lands
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SEL  = 2'd1,   // chosen by the destination bit
    TGT_ACC  = 2'd2,
    TGT_REG  = 2'd3
  } acu_tgt_e;
endpackage

// File: rtl/acu_calc.sv
module acu_calc
  import acu_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  acu_op_e         op,
  input  logic [DW-1:0]   acc,
  input  logic [DW-1:0]   rdata,
  input  logic [DW-1:0]   imm,
  input  logic [BW-1:0]   bsel,
  input  logic            c_in,
  output logic [DW-1:0]   res,
  output logic            c_new,
  output logic            dc_new,
  output logic            z_en,
  output logic            c_en,
  output logic            dc_en,
  output acu_tgt_e        tgt,
  output logic            is_skip
);
  localparam int HALF = DW / 2;

  // returns {carry out, half carry out, sum}
  function automatic logic [DW+1:0] add_f(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic ci);
    logic [HALF:0] lo;
    logic [DW:0]   full;
    lo   = {1'b0, x[HALF-1:0]} + {1'b0, y[HALF-1:0]} + {{HALF{1'b0}}, ci};
    full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    return {full[DW], lo[HALF], full[DW-1:0]};
  endfunction

  function automatic logic [DW-1:0] swap_f(input logic [DW-1:0] x);
    return {x[HALF-1:0], x[DW-1:HALF]};
  endfunction

  logic [DW-1:0] bmask;
  assign bmask = {{(DW-1){1'b0}}, 1'b1} << bsel;

  always_comb begin
    res     = '0;
    c_new   = c_in;
    dc_new  = 1'b0;
    z_en    = 1'b0;
    c_en    = 1'b0;
    dc_en   = 1'b0;
    tgt     = TGT_NONE;
    is_skip = 1'b0;
    unique case (op)
      OP_ADD: begin
        {c_new, dc_new, res} = add_f(acc, rdata, 1'b0);
        z_en = 1'b1; c_en = 1'b1; dc_en = 1'b1; tgt = TGT_SEL;
      end
      OP_SUB: begin  // register minus accumulator, carry = no borrow
        {c_new, dc_new, res} = add_f(rdata, ~acc, 1'b1);
        z_en = 1'b1; c_en = 1'b1; dc_en = 1'b1; tgt = TGT_SEL;
      end
      OP_AND:   begin res = acc & rdata; z_en = 1'b1; tgt = TGT_SEL; end
      OP_OR:    begin res = acc | rdata; z_en = 1'b1; tgt = TGT_SEL; end
      OP_XOR:   begin res = acc ^ rdata; z_en = 1'b1; tgt = TGT_SEL; end
      OP_NOT:   begin res = ~rdata;      z_en = 1'b1; tgt = TGT_SEL; end
      OP_CLR:   begin res = '0;          z_en = 1'b1; tgt = TGT_SEL; end
      OP_MOV:   begin res = rdata;       z_en = 1'b1; tgt = TGT_SEL; end
      OP_INC:   begin res = rdata + DW'(1); z_en = 1'b1; tgt = TGT_SEL; end
      OP_DEC:   begin res = rdata - DW'(1); z_en = 1'b1; tgt = TGT_SEL; end
      OP_INCSZ: begin res = rdata + DW'(1); is_skip = 1'b1; tgt = TGT_SEL; end
      OP_DECSZ: begin res = rdata - DW'(1); is_skip = 1'b1; tgt = TGT_SEL; end
      OP_ROL: begin
        res = {rdata[DW-2:0], c_in}; c_new = rdata[DW-1];
        c_en = 1'b1; tgt = TGT_SEL;
      end
      OP_ROR: begin
        res = {c_in, rdata[DW-1:1]}; c_new = rdata[0];
        c_en = 1'b1; tgt = TGT_SEL;
      end
      OP_SWAP:  begin res = swap_f(rdata);    tgt = TGT_SEL; end
      OP_BSET:  begin res = rdata | bmask;    tgt = TGT_REG; end
      OP_BCLR:  begin res = rdata & ~bmask;   tgt = TGT_REG; end
      OP_MOVA:  begin res = acc;              tgt = TGT_REG; end
      OP_ANDI:  begin res = acc & imm; z_en = 1'b1; tgt = TGT_ACC; end
      OP_ORI:   begin res = acc | imm; z_en = 1'b1; tgt = TGT_ACC; end
      OP_XORI:  begin res = acc ^ imm; z_en = 1'b1; tgt = TGT_ACC; end
      OP_MOVI:  begin res = imm;                   tgt = TGT_ACC; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/acu_state.sv
module acu_state #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_we,
  input  logic [DW-1:0] res,
  input  logic          z_en,
  input  logic          c_en,
  input  logic          dc_en,
  input  logic          c_new,
  input  logic          dc_new,
  output logic [DW-1:0] acc_q,
  output logic          z_q,
  output logic          c_q,
  output logic          dc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
      dc_q  <= 1'b0;
    end else begin
      if (acc_we) acc_q <= res;
      if (z_en)   z_q   <= ~|res;
      if (c_en)   c_q   <= c_new;
      if (dc_en)  dc_q  <= dc_new;
    end
  end

  AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !z_en |=> $stable(z_q));  // R9
  AST_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !c_en |=> $stable(c_q));  // R4
  AST_DC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dc_en |=> $stable(dc_q));  // R10
endmodule

// File: rtl/acu_exec.sv
module acu_exec
  import acu_pkg::*;
#(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    op_code,
  input  logic          dest_reg,
  input  logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] imm,
  input  logic [BW-1:0] bit_sel,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  output logic          skip,
  output logic [DW-1:0] acc,
  output logic          flag_z,
  output logic          flag_c,
  output logic          flag_dc
);
  acu_op_e       op_e;
  acu_tgt_e      tgt;
  logic [DW-1:0] alu_res;
  logic          c_new, dc_new, z_en, c_en, dc_en, is_skip;
  logic          acc_we;

  assign op_e = acu_op_e'(op_code);

  acu_calc #(.DW(DW)) u_calc (
    .op(op_e), .acc(acc), .rdata(reg_rdata), .imm(imm), .bsel(bit_sel),
    .c_in(flag_c), .res(alu_res), .c_new(c_new), .dc_new(dc_new),
    .z_en(z_en), .c_en(c_en), .dc_en(dc_en), .tgt(tgt), .is_skip(is_skip)
  );

  // target decode, gated by the valid strobe
  assign acc_we = op_valid && ((tgt == TGT_ACC) || ((tgt == TGT_SEL) && !dest_reg));
  assign reg_we = op_valid && ((tgt == TGT_REG) || ((tgt == TGT_SEL) && dest_reg));
  assign reg_wdata = alu_res;
  assign skip = op_valid && is_skip && (alu_res == '0);

  acu_state #(.DW(DW)) u_state (
    .clk(clk), .rst_n(rst_n), .acc_we(acc_we), .res(alu_res),
    .z_en(op_valid && z_en), .c_en(op_valid && c_en), .dc_en(op_valid && dc_en),
    .c_new(c_new), .dc_new(dc_new),
    .acc_q(acc), .z_q(flag_z), .c_q(flag_c), .dc_q(flag_dc)
  );

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_we && reg_we));  // R5
  AST_REG_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> $stable(acc));  // R5
  AST_ACC_TAKES_RES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> (acc == $past(alu_res)));  // R5
  AST_SKIP_ZERO_RES: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (reg_we || acc_we) && !z_en);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc) && $stable(flag_z) && $stable(flag_c) && $stable(flag_dc));  // R13
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !reg_we && !skip);  // R13
endmodule

// File: tb/sim_acu_exec.sv
module sim_acu_exec;
  localparam int OP_NOP = 0, OP_ADD = 1, OP_SUB = 2, OP_AND = 3, OP_OR = 4,
                 OP_XOR = 5, OP_NOT = 6, OP_CLR = 7, OP_MOV = 8, OP_INC = 9,
                 OP_DEC = 10, OP_INCSZ = 11, OP_DECSZ = 12, OP_ROL = 13,
                 OP_ROR = 14, OP_SWAP = 15, OP_BSET = 16, OP_BCLR = 17,
                 OP_MOVA = 18, OP_ANDI = 19, OP_ORI = 20, OP_XORI = 21,
                 OP_MOVI = 22;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic       dest_reg = 1'b0;
  logic [7:0] reg_rdata = '0, imm = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] reg_wdata, acc;
  logic       reg_we, skip, flag_z, flag_c, flag_dc;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_acc = 0, m_z = 0, m_c = 0, m_dc = 0;

  always #5 clk = ~clk;

  acu_exec u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dest_reg(dest_reg), .reg_rdata(reg_rdata), .imm(imm), .bit_sel(bit_sel),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .skip(skip), .acc(acc),
    .flag_z(flag_z), .flag_c(flag_c), .flag_dc(flag_dc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      OP_ADD: return "R2";
      OP_SUB: return "R3";
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_CLR, OP_MOV: return "R4";
      OP_INC, OP_DEC: return "R7";
      OP_INCSZ, OP_DECSZ: return "R8";
      OP_ROL, OP_ROR: return "R9";
      OP_SWAP: return "R10";
      OP_BSET, OP_BCLR: return "R11";
      OP_MOVA: return "R12";
      OP_ANDI, OP_ORI, OP_XORI, OP_MOVI: return "R6";
      default: return "R13";
    endcase
  endfunction

  // reference model: tg 0 none, 1 by dest, 2 acc, 3 reg
  task automatic run(input int op, input int dst, input int r, input int im, input int bs);
    int res = 0, tg = 0, zen = 0, nc = m_c, ndc = m_dc, cen = 0, dcen = 0, sk = 0;
    int ewe, eacc;
    string rq = req_of(op);
    case (op)
      OP_ADD: begin res = (m_acc + r) % 256; nc = (m_acc + r) > 255;
        ndc = (m_acc % 16 + r % 16) > 15; zen = 1; cen = 1; dcen = 1; tg = 1; end
      OP_SUB: begin res = (r - m_acc + 256) % 256; nc = r >= m_acc;
        ndc = (r % 16) >= (m_acc % 16); zen = 1; cen = 1; dcen = 1; tg = 1; end
      OP_AND: begin res = m_acc & r; zen = 1; tg = 1; end
      OP_OR:  begin res = m_acc | r; zen = 1; tg = 1; end
      OP_XOR: begin res = m_acc ^ r; zen = 1; tg = 1; end
      OP_NOT: begin res = 255 - r; zen = 1; tg = 1; end
      OP_CLR: begin res = 0; zen = 1; tg = 1; end
      OP_MOV: begin res = r; zen = 1; tg = 1; end
      OP_INC: begin res = (r + 1) % 256; zen = 1; tg = 1; end
      OP_DEC: begin res = (r + 255) % 256; zen = 1; tg = 1; end
      OP_INCSZ: begin res = (r + 1) % 256; sk = (res == 0); tg = 1; end
      OP_DECSZ: begin res = (r + 255) % 256; sk = (res == 0); tg = 1; end
      OP_ROL: begin res = (r * 2) % 256 + m_c; nc = r / 128; cen = 1; tg = 1; end
      OP_ROR: begin res = r / 2 + m_c * 128; nc = r % 2; cen = 1; tg = 1; end
      OP_SWAP: begin res = (r % 16) * 16 + r / 16; tg = 1; end
      OP_BSET: begin res = r | (1 << bs); tg = 3; end
      OP_BCLR: begin res = r & (255 - (1 << bs)); tg = 3; end
      OP_MOVA: begin res = m_acc; tg = 3; end
      OP_ANDI: begin res = m_acc & im; zen = 1; tg = 2; end
      OP_ORI:  begin res = m_acc | im; zen = 1; tg = 2; end
      OP_XORI: begin res = m_acc ^ im; zen = 1; tg = 2; end
      OP_MOVI: begin res = im; tg = 2; end
      default: ;
    endcase
    ewe  = (tg == 3) || (tg == 1 && dst == 1);
    eacc = ((tg == 2) || (tg == 1 && dst == 0)) ? res : m_acc;
    @(negedge clk);
    op_valid = 1'b1; op_code = op[4:0]; dest_reg = dst[0];
    reg_rdata = r[7:0]; imm = im[7:0]; bit_sel = bs[2:0];
    #2;
    chk(rq, "reg_we", int'(reg_we), ewe);
    if (ewe) chk(rq, "reg_wdata", int'(reg_wdata), res);
    chk(rq, "skip", int'(skip), sk);
    @(posedge clk); #2;
    if (zen) m_z = (res == 0);
    if (cen) m_c = nc;
    if (dcen) m_dc = ndc;
    m_acc = eacc;
    chk(rq, "acc", int'(acc), m_acc);
    chk(rq, "flag_z", int'(flag_z), m_z);
    chk(rq, "flag_c", int'(flag_c), m_c);
    chk(rq, "flag_dc", int'(flag_dc), m_dc);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset values
    chk("R1", "acc", int'(acc), 0);
    chk("R1", "flags", int'({flag_z, flag_c, flag_dc}), 0);
    chk("R1", "reg_we", int'(reg_we), 0);
    chk("R1", "skip", int'(skip), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1", "acc after release", int'(acc), 0);

    // R2 / R3 near-exhaustive
    for (int a = 0; a < 256; a += 4)
      for (int r = 0; r < 256; r++) begin
        run(OP_MOVI, 1, 0, a, 0);
        run(OP_ADD, 0, r, 0, 0);
        run(OP_MOVI, 0, 0, a, 0);
        run(OP_SUB, r % 2, r, 0, 0);
      end

    // register-operand sweeps, both destinations (R4 R5 R7 R8 R9 R10)
    for (int d = 0; d < 2; d++)
      for (int r = 0; r < 256; r++) begin
        run(OP_MOVI, 0, 0, (r * 37) % 256, 0);
        run(OP_AND, d, r, 0, 0);
        run(OP_OR, d, r, 0, 0);
        run(OP_XOR, d, r, 0, 0);
        run(OP_NOT, d, r, 0, 0);
        run(OP_MOV, d, r, 0, 0);
        run(OP_CLR, d, r, 0, 0);
        run(OP_INC, d, r, 0, 0);
        run(OP_DEC, d, r, 0, 0);
        run(OP_INCSZ, d, r, 0, 0);
        run(OP_DECSZ, d, r, 0, 0);
        run(OP_ROL, d, r, 0, 0);
        run(OP_ROR, d, (r * 5) % 256, 0, 0);
        run(OP_SWAP, d, r, 0, 0);
      end

    // R6 immediates, R11 bits, R12 MOVA
    for (int v = 0; v < 256; v++) begin
      run(OP_MOVI, 1, 0, v, 0);
      run(OP_ANDI, 1, 0, (v * 3) % 256, 0);
      run(OP_ORI, 0, 0, (v * 7) % 256, 0);
      run(OP_XORI, 1, 0, v, 0);
      run(OP_MOVA, 0, 0, 0, 0);
      run(OP_BSET, 0, v, 0, v % 8);
      run(OP_BCLR, 0, v, 0, (v / 8) % 8);
    end

    // R13 unlisted codes and idle cycles
    run(OP_MOVI, 0, 0, 8'h5a, 0);
    for (int k = 23; k < 32; k++) run(k, 1, 0, 8'hff, 0);
    run(OP_NOP, 1, 8'hff, 0, 0);
    @(negedge clk);
    op_valid = 1'b0; op_code = 5'(OP_INCSZ); dest_reg = 1'b1; reg_rdata = 8'hff;
    #2;
    chk("R13", "idle reg_we", int'(reg_we), 0);
    chk("R13", "idle skip", int'(skip), 0);
    @(posedge clk); #2;
    chk("R13", "idle acc", int'(acc), m_acc);
    chk("R13", "idle flags", int'({flag_z, flag_c, flag_dc}), m_z * 4 + m_c * 2 + m_dc);
    finish_run();
  end
endmodule